// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds for precision time protocol use. Every enabled reference clock cycle, a 32-bit fractional addend is summed into a 32-bit phase accumulator. Each time that sum wraps past 2^32, the time value advances by a programmed nominal clock period in whole nanoseconds. Software trims the clock rate by rewriting the addend, and it can bypass the accumulator so that time advances by the period on every cycle.

Software reaches the block through a small word-addressed register bus. The 64-bit time value and a signed 64-bit step offset are each reached as two 32-bit halves. Ordering rules make wide reads and wide writes atomic: the low half goes first and the high half completes the access. A level-sensitive soft reset bit clears the running state and keeps the configuration.

Top module: `time_counter`

## Requirements
- R1: After rst_n is deasserted, every register reads zero and time_ns is zero.
- R2: Word addresses are control=0, addend=1, accumulator=2, time low=3, time high=4, step low=5, step high=6. The control word has the period in bits 25:16, soft reset in bit 5, bypass in bit 3 and enable in bit 2, with all other bits reading zero. A read presents its data on bus_rdata in the cycle after bus_rd. The control and addend registers read back what was written.
- R3: With enable set and bypass clear, each cycle the accumulator becomes (accumulator + addend) mod 2^32. When that sum carries out of bit 31, time_ns grows by the period. Otherwise time_ns holds.
- R4: With enable clear, time_ns and the accumulator do not advance.
- R5: With enable and bypass both set, time_ns grows by the period every cycle and the accumulator holds.
- R6: Writing time low and then time high loads {high, low} into time_ns on the clock edge that takes the high write.
- R7: A time low write with no time high write after it leaves the running time unchanged.
- R8: A time low read latches the upper 32 bits of that same instant. A later time high read returns that latched value, even if the time has advanced since.
- R9: Writing step low and then step high adds the signed 64-bit value {high, low} to time_ns on the clock edge that takes the high write.
- R10: The accumulator is readable and writable. An addend write does not change the accumulator, and the new addend is used from the next cycle on.
- R11: While soft reset is set, time_ns, the accumulator, the pending low halves and the read latch are cleared. The period, bypass and addend are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The bench sweeps addends that carry every cycle, every fourth cycle, almost never, and at odd ratios. It runs each for several enabled-cycle counts and two periods. It checks both the accumulated time and the residual accumulator phase against floor(N*A/2^32), so a dropped or doubled carry, or an off-by-one enable window, changes the result. To catch a design that returns the live upper half instead of the latched one, the bench parks the time just below a 32-bit rollover, reads the low half, steps across the boundary and then reads the high half. Orphan low writes, addend rewrites over a preloaded accumulator, and a soft reset with a pending low half are each aimed at a design that lets stale latched state leak into the running time.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_ADDEND  = 3'd1,
        RA_ACC     = 3'd2,
        RA_TIME_LO = 3'd3,
        RA_TIME_HI = 3'd4,
        RA_STEP_LO = 3'd5,
        RA_STEP_HI = 3'd6
    } reg_addr_e;

    localparam int CTL_EN_BIT   = 2;
    localparam int CTL_BYP_BIT  = 3;
    localparam int CTL_SRST_BIT = 5;
    localparam int CTL_PER_LSB  = 16;
endpackage

// File: rtl/tc_accum.sv
module tc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [ACC_W-1:0] addend,
    input  logic             acc_wr,
    input  logic [ACC_W-1:0] acc_wdata,
    output logic [ACC_W-1:0] acc,
    output logic             carry
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum_w;

    always_comb begin
        st_d  = st_q;
        sum_w = {1'b0, st_q.acc} + {1'b0, addend};
        carry = run && sum_w[ACC_W];
        if (clr)
            st_d.acc = '0;
        else if (acc_wr)
            st_d.acc = acc_wdata;
        else if (run)
            st_d.acc = sum_w[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/tc_count.sv
module tc_count #(
    parameter int CNT_W = 64,
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [CNT_W-1:0] step_val,
    input  logic             adv,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (load)
            st_d.cnt = load_val;
        else if (step)
            st_d.cnt = st_q.cnt + step_val;
        else if (adv)
            st_d.cnt = st_q.cnt + {{(CNT_W-PER_W){1'b0}}, period};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/time_counter.sv
module time_counter
    import tc_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int PER_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [2:0]           bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [2*BUS_W-1:0]   time_ns
);
    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic             en;
        logic             byp;
        logic             srst;
        logic [PER_W-1:0] period;
        logic [BUS_W-1:0] addend;
        logic [BUS_W-1:0] time_lo_pend;
        logic [BUS_W-1:0] step_lo_pend;
        logic [BUS_W-1:0] hi_snap;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [BUS_W-1:0] acc_w;
    logic [CNT_W-1:0] cnt_w;
    logic             carry_w;
    logic             wr_acc, wr_time_hi, wr_step_hi;
    logic [BUS_W-1:0] ctrl_word;
    logic             run_acc, adv_cnt;

    always_comb begin
        r_d        = r_q;
        wr_acc     = bus_wr && (bus_addr == RA_ACC);
        wr_time_hi = bus_wr && (bus_addr == RA_TIME_HI);
        wr_step_hi = bus_wr && (bus_addr == RA_STEP_HI);

        ctrl_word                             = '0;
        ctrl_word[CTL_PER_LSB +: PER_W]       = r_q.period;
        ctrl_word[CTL_SRST_BIT]               = r_q.srst;
        ctrl_word[CTL_BYP_BIT]                = r_q.byp;
        ctrl_word[CTL_EN_BIT]                 = r_q.en;

        if (bus_wr) begin
            case (bus_addr)
                RA_CTRL: begin
                    r_d.en     = bus_wdata[CTL_EN_BIT];
                    r_d.byp    = bus_wdata[CTL_BYP_BIT];
                    r_d.srst   = bus_wdata[CTL_SRST_BIT];
                    r_d.period = bus_wdata[CTL_PER_LSB +: PER_W];
                end
                RA_ADDEND:  r_d.addend       = bus_wdata;
                RA_TIME_LO: r_d.time_lo_pend = bus_wdata;
                RA_STEP_LO: r_d.step_lo_pend = bus_wdata;
                default: ;
            endcase
        end

        if (bus_rd) begin
            case (bus_addr)
                RA_CTRL:    r_d.rdata = ctrl_word;
                RA_ADDEND:  r_d.rdata = r_q.addend;
                RA_ACC:     r_d.rdata = acc_w;
                RA_TIME_LO: begin
                    r_d.rdata   = cnt_w[BUS_W-1:0];
                    r_d.hi_snap = cnt_w[CNT_W-1:BUS_W];
                end
                RA_TIME_HI: r_d.rdata = r_q.hi_snap;
                RA_STEP_LO: r_d.rdata = r_q.step_lo_pend;
                default:    r_d.rdata = '0;
            endcase
        end

        if (r_q.srst) begin
            r_d.time_lo_pend = '0;
            r_d.step_lo_pend = '0;
            r_d.hi_snap      = '0;
        end

        run_acc = r_q.en && !r_q.byp;
        adv_cnt = r_q.en && (r_q.byp || carry_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    tc_accum #(.ACC_W(BUS_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (r_q.srst),
        .run       (run_acc),
        .addend    (r_q.addend),
        .acc_wr    (wr_acc),
        .acc_wdata (bus_wdata),
        .acc       (acc_w),
        .carry     (carry_w)
    );

    tc_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (r_q.srst),
        .load     (wr_time_hi),
        .load_val ({bus_wdata, r_q.time_lo_pend}),
        .step     (wr_step_hi),
        .step_val ({bus_wdata, r_q.step_lo_pend}),
        .adv      (adv_cnt),
        .period   (r_q.period),
        .count    (cnt_w)
    );

    assign bus_rdata = r_q.rdata;
    assign time_ns   = cnt_w;
endmodule

// File: rtl/time_counter_chk.sv
module time_counter_chk #(
    parameter int BUS_W = 32,
    parameter int PER_W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 byp,
    input logic                 srst,
    input logic [PER_W-1:0]     period,
    input logic [BUS_W-1:0]     addend,
    input logic [BUS_W-1:0]     acc,
    input logic                 acc_wr,
    input logic [2*BUS_W-1:0]   count,
    input logic                 ld,
    input logic [2*BUS_W-1:0]   ld_val,
    input logic                 stp
);
    localparam int CNT_W = 2 * BUS_W;
    logic quiet;
    assign quiet = !srst && !ld && !stp;

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && quiet && !acc_wr) |=> (count == $past(count) && acc == $past(acc)));

    // R5
    bypass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && byp && quiet) |=>
            (count == $past(count) + {{(CNT_W-PER_W){1'b0}}, $past(period)}));

    // R3
    acc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !byp && !srst && !acc_wr) |=> (acc == $past(acc) + $past(addend)));

    // R3
    carry_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !byp && quiet) |=>
            (count == $past(count) ||
             count == $past(count) + {{(CNT_W-PER_W){1'b0}}, $past(period)}));

    // R6
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !srst) |=> (count == $past(ld_val)));

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (count == '0 && acc == '0));
endmodule

bind time_counter time_counter_chk #(.BUS_W(BUS_W), .PER_W(PER_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (r_q.en),
    .byp    (r_q.byp),
    .srst   (r_q.srst),
    .period (r_q.period),
    .addend (r_q.addend),
    .acc    (acc_w),
    .acc_wr (wr_acc),
    .count  (cnt_w),
    .ld     (wr_time_hi),
    .ld_val ({bus_wdata, r_q.time_lo_pend}),
    .stp    (wr_step_hi)
);

// File: tb/tb_time_counter.sv
module tb_time_counter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] time_ns;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    time_counter dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .time_ns(time_ns)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_ADD = 3'd1, A_ACC = 3'd2,
        A_TLO = 3'd3, A_THI = 3'd4, A_SLO = 3'd5, A_SHI = 3'd6;

    function automatic logic [31:0] ctl(input logic en, input logic byp,
                                        input logic sr, input logic [9:0] per);
        return {6'd0, per, 10'd0, sr, 1'b0, byp, en, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd64(output logic [63:0] v);
        logic [31:0] lo, hi;
        br(A_TLO, lo);
        br(A_THI, hi);
        v = {hi, lo};
    endtask

    task automatic soft_reset(input logic [9:0] per);
        bw(A_CTRL, ctl(1'b0, 1'b0, 1'b1, per));
        bw(A_CTRL, ctl(1'b0, 1'b0, 1'b0, per));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v, v2, prod, exp_t;
        logic [31:0] addends [6];
        int          lens [3];
        logic [9:0]  pers [2];
        addends = '{32'h4000_0000, 32'h8000_0001, 32'hFFFF_FFFF,
                    32'h1000_0000, 32'h5555_5556, 32'h0000_0001};
        lens = '{1, 7, 33};
        pers = '{10'd8, 10'd1023};

        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        br(A_CTRL, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
        br(A_ADD, d);  chk("R1 addend", {32'd0, d}, 64'd0);
        br(A_ACC, d);  chk("R1 acc", {32'd0, d}, 64'd0);
        rd64(v);       chk("R1 time", v, 64'd0);
        chk("R1 time_ns", time_ns, 64'd0);

        // R2 readback
        bw(A_CTRL, 32'hFFFF_FFFF & ~32'h0000_0024);
        br(A_CTRL, d); chk("R2 ctrl fields", {32'd0, d}, {32'd0, ctl(1'b0, 1'b1, 1'b0, 10'h3FF)});
        bw(A_ADD, 32'hDEAD_BEEF);
        br(A_ADD, d);  chk("R2 addend", {32'd0, d}, 64'hDEAD_BEEF);

        // R3 sweep of addend x length x period
        foreach (pers[p]) foreach (addends[i]) foreach (lens[k]) begin
            soft_reset(pers[p]);
            bw(A_ADD, addends[i]);
            bw(A_CTRL, ctl(1'b1, 1'b0, 1'b0, pers[p]));
            repeat (lens[k] - 1) @(negedge clk);
            bw(A_CTRL, ctl(1'b0, 1'b0, 1'b0, pers[p]));
            prod  = 64'(lens[k]) * {32'd0, addends[i]};
            exp_t = {32'd0, prod[63:32]} * {54'd0, pers[p]};
            rd64(v);       chk("R3 time after N cycles", v, exp_t);
            br(A_ACC, d);  chk("R3 acc residue", {32'd0, d}, {32'd0, prod[31:0]});
        end

        // R4 disabled: nothing moves
        rd64(v);
        repeat (20) @(negedge clk);
        rd64(v2);      chk("R4 time held", v2, v);
        chk("R4 time_ns held", time_ns, v);

        // R5 bypass
        soft_reset(10'd5);
        bw(A_ADD, 32'h8000_0000);
        bw(A_CTRL, ctl(1'b1, 1'b1, 1'b0, 10'd5));
        repeat (9) @(negedge clk);
        bw(A_CTRL, ctl(1'b0, 1'b1, 1'b0, 10'd5));
        rd64(v);       chk("R5 bypass time", v, 64'd50);
        br(A_ACC, d);  chk("R5 acc held", {32'd0, d}, 64'd0);

        // R6 wide write, R7 orphan low write
        bw(A_CTRL, ctl(1'b0, 1'b0, 1'b0, 10'd5));
        bw(A_TLO, 32'h1234_5678);
        chk("R6 no change before high", time_ns, 64'd50);
        bw(A_THI, 32'h0000_00AB);
        rd64(v);       chk("R6 loaded", v, 64'h0000_00AB_1234_5678);
        bw(A_TLO, 32'h0BAD_0BAD);
        repeat (3) @(negedge clk);
        rd64(v);       chk("R7 orphan low", v, 64'h0000_00AB_1234_5678);

        // R8 snapshot across a step (R9)
        bw(A_TLO, 32'hFFFF_FFFF);
        bw(A_THI, 32'h0000_0001);
        br(A_TLO, d);  chk("R8 low", {32'd0, d}, 64'hFFFF_FFFF);
        bw(A_SLO, 32'h0000_0001);
        bw(A_SHI, 32'h0000_0000);
        br(A_THI, d);  chk("R8 high from snapshot", {32'd0, d}, 64'd1);
        chk("R9 step +1", time_ns, 64'h0000_0002_0000_0000);
        bw(A_SLO, 32'hFFFF_FF00);
        bw(A_SHI, 32'hFFFF_FFFF);
        rd64(v);       chk("R9 step -256", v, 64'h0000_0001_FFFF_FF00);

        // R10 accumulator access and addend independence
        soft_reset(10'd7);
        bw(A_ACC, 32'h1234_5678);
        bw(A_ADD, 32'h0000_0010);
        br(A_ACC, d);  chk("R10 acc kept on addend write", {32'd0, d}, 64'h1234_5678);
        bw(A_CTRL, ctl(1'b1, 1'b0, 1'b0, 10'd7));
        bw(A_CTRL, ctl(1'b0, 1'b0, 1'b0, 10'd7));
        br(A_ACC, d);  chk("R10 one accumulation", {32'd0, d}, 64'h1234_5688);
        bw(A_ACC, 32'hFFFF_FFF8);
        bw(A_CTRL, ctl(1'b1, 1'b0, 1'b0, 10'd7));
        bw(A_CTRL, ctl(1'b0, 1'b0, 1'b0, 10'd7));
        chk("R10 preloaded acc carries", time_ns, 64'd7);

        // R11 soft reset keeps config, drops pending low half
        bw(A_TLO, 32'hAAAA_AAAA);
        bw(A_CTRL, ctl(1'b0, 1'b1, 1'b1, 10'd7));
        bw(A_CTRL, ctl(1'b0, 1'b1, 1'b0, 10'd7));
        rd64(v);       chk("R11 time cleared", v, 64'd0);
        br(A_ACC, d);  chk("R11 acc cleared", {32'd0, d}, 64'd0);
        br(A_ADD, d);  chk("R11 addend kept", {32'd0, d}, 64'h10);
        br(A_CTRL, d); chk("R11 ctrl kept", {32'd0, d}, {32'd0, ctl(1'b0, 1'b1, 1'b0, 10'd7)});
        bw(A_THI, 32'h0000_0005);
        chk("R11 pending low cleared", time_ns, 64'h0000_0005_0000_0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule